// File: doc/BRIEF.md
# Command Packet Decoder for a Byte-Stream Link

This block turns packets that arrive as a byte stream into accesses on an internal byte-wide register bus and a set of FIFO-like ports. It also builds the reply packets for read commands. Every packet opens with one command byte. The top bit of that byte chooses read or write, and the seven low bits give an address. Addresses below a parameterised base select single-byte registers. Addresses at or above that base select ports, which take or supply any number of bytes.

Both streams use a valid/ready handshake. Each beat carries a byte and an end flag. A beat with the end flag set is the end-of-packet marker: it is a beat of its own, and its data byte is not used. A register write is committed only after its end marker arrives, so a malformed packet never reaches the bus. Malformed packets are dropped and reported by a one-cycle error pulse.

Top module: `cmdpkt_decoder`

## Requirements
- R1: During reset and in the first cycle after it, `out_valid`, `reg_wr`, `reg_rd`, `port_push`, `port_pop` and `bad_pkt` are 0 and `in_ready` is 1.
- R2: Command byte bit 7 = 1 means read and 0 means write. Bits 6..0 are the address. An address below `PORT_BASE` selects a register, and any other address selects a port. The address is presented on `bus_addr` for every access the command causes.
- R3: The sequence write command byte, one value byte, end marker causes exactly one `reg_wr` pulse. The pulse comes in the cycle after the end marker is accepted and carries the command's address and the value byte.
- R4: The sequence read command byte directly followed by an end marker produces a reply. The reply is the command byte, then the register value sampled in the one cycle where `reg_rd` is high, then an end beat (`out_eop`=1, `out_data`=0).
- R5: Each data byte of a port write pulses `port_push` with that byte on `port_wdata` and the command's address, in arrival order. While `port_full` is 1, no data byte is taken (`in_ready`=0). An end marker right after the command byte is legal and pushes nothing.
- R6: A port read request produces a reply. The reply is the command byte, then bytes popped from the port (one `port_pop` per byte sent) until `port_empty` or `RD_LIMIT` bytes, then an end beat. Bytes beyond the limit stay in the port.
- R7: Four cases are malformed: a write with no value byte, a register write with more than one value byte, any read with a byte before its end marker, and an end marker with no command. Such a packet causes no bus access and no reply. `bad_pkt` pulses in the cycle after its end marker.
- R8: While a reply is pending, `in_ready` is 0. While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_eop` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Decoder takes the input beat |
| in_data | input | 8 | Input byte |
| in_eop | input | 1 | Input beat is an end-of-packet marker |
| out_valid | output | 1 | Reply beat valid |
| out_ready | input | 1 | Consumer takes the reply beat |
| out_data | output | 8 | Reply byte (0 on end beats) |
| out_eop | output | 1 | Reply beat is an end-of-packet marker |
| bus_addr | output | 7 | Register or port address of the current command |
| reg_wr | output | 1 | Register write strobe |
| reg_wdata | output | 8 | Register write value |
| reg_rd | output | 1 | Register read strobe |
| reg_rdata | input | 8 | Register read value at `bus_addr` |
| port_push | output | 1 | Push one byte into the addressed port |
| port_wdata | output | 8 | Byte pushed into the port |
| port_full | input | 1 | Addressed port cannot accept a byte |
| port_pop | output | 1 | Pop the head byte of the addressed port |
| port_rdata | input | 8 | Head byte of the addressed port |
| port_empty | input | 1 | Addressed port has no byte |
| bad_pkt | output | 1 | One-cycle pulse for a dropped malformed packet |

## Verification
The bench builds the decoder with `PORT_BASE` = 96 and `RD_LIMIT` = 4. With these values, address 95 is the last register and address 96 is the first port. A short port read therefore hits the empty stop, and a six-byte port source hits the length stop and leaves two bytes behind. The small limit also keeps both read endings within a few dozen cycles. Malformed packets aimed at an already written register show, through a later read, that the value is unchanged.

// File: rtl/cmdpkt_pkg.sv
// Shared types for the command packet decoder.
// Assumes the fixed command format: one byte, bit 7 = read, bits 6..0 = address.
package cmdpkt_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W - 1;

    typedef enum logic [1:0] {
        KIND_REG_WR,
        KIND_REG_RD,
        KIND_PORT_WR,
        KIND_PORT_RD
    } cmd_kind_t;

    typedef enum logic [2:0] {
        RS_IDLE,
        RS_HEAD,
        RS_FETCH,
        RS_VALUE,
        RS_PORT,
        RS_TAIL
    } reply_state_t;

    // Sort a command byte into one of the four access kinds.
    function automatic cmd_kind_t classify(input logic [BYTE_W-1:0] cmd,
                                           input logic [ADDR_W-1:0] base);
        logic is_port;
        is_port = (cmd[ADDR_W-1:0] >= base);
        if (cmd[BYTE_W-1])
            return is_port ? KIND_PORT_RD : KIND_REG_RD;
        else
            return is_port ? KIND_PORT_WR : KIND_REG_WR;
    endfunction

endpackage

// File: rtl/cmdpkt_parser.sv
// Input side of the decoder: takes beats from the byte stream, keeps the
// command byte, counts body bytes, streams port-write data, commits register
// writes at the end marker and starts replies for well-formed reads.
// Assumes: 'hold' is high whenever a reply is pending or about to start.
module cmdpkt_parser
    import cmdpkt_pkg::*;
#(
    parameter int PORT_BASE = 96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_eop,
    input  logic              hold,
    input  logic              port_full,
    output logic              in_ready,
    output logic [BYTE_W-1:0] cmd_q,
    output logic              reg_wr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              port_push,
    output logic              launch,
    output logic              bad_pkt
);

    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(PORT_BASE);

    logic              in_body;
    logic [1:0]        body_cnt;
    logic [BYTE_W-1:0] val_q;
    cmd_kind_t         kind;
    logic              fire;

    // Kind of the command being received.
    assign kind      = classify(cmd_q, BASE);
    // Stall on a pending reply, or on port data while the port is full.
    assign in_ready  = !hold && !(in_body && (kind == KIND_PORT_WR) && !in_eop && port_full);
    assign fire      = in_valid && in_ready;
    // Port data passes straight through to the port.
    assign port_push = fire && in_body && !in_eop && (kind == KIND_PORT_WR);
    assign reg_wdata = val_q;

    // Packet framing, body counting, and commit or reject at the end marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_body  <= 1'b0;
            body_cnt <= '0;
            cmd_q    <= '0;
            val_q    <= '0;
            reg_wr   <= 1'b0;
            launch   <= 1'b0;
            bad_pkt  <= 1'b0;
        end else begin
            reg_wr  <= 1'b0;
            launch  <= 1'b0;
            bad_pkt <= 1'b0;
            if (fire) begin
                if (!in_body) begin
                    if (in_eop) begin
                        bad_pkt <= 1'b1;
                    end else begin
                        cmd_q    <= in_data;
                        in_body  <= 1'b1;
                        body_cnt <= '0;
                    end
                end else if (!in_eop) begin
                    if (body_cnt == 2'd0)
                        val_q <= in_data;
                    if (body_cnt != 2'd2)
                        body_cnt <= body_cnt + 2'd1;
                end else begin
                    in_body <= 1'b0;
                    unique case (kind)
                        KIND_REG_WR: begin
                            if (body_cnt == 2'd1) reg_wr  <= 1'b1;
                            else                  bad_pkt <= 1'b1;
                        end
                        KIND_PORT_WR: begin
                            in_body <= 1'b0;
                        end
                        default: begin
                            if (body_cnt == 2'd0) launch  <= 1'b1;
                            else                  bad_pkt <= 1'b1;
                        end
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/cmdpkt_reply.sv
// Output side of the decoder: builds the reply packet for a register read
// (command, value, end) or a port read (command, port bytes, end).
// Assumes: cmd_q stays stable while busy; the port does not refill while
// a reply beat is stalled.
module cmdpkt_reply
    import cmdpkt_pkg::*;
#(
    parameter int RD_LIMIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [BYTE_W-1:0] cmd_q,
    input  logic              is_port,
    input  logic [BYTE_W-1:0] reg_rdata,
    input  logic [BYTE_W-1:0] port_rdata,
    input  logic              port_empty,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_eop,
    output logic              reg_rd,
    output logic              port_pop,
    output logic              busy
);

    localparam int CW = $clog2(RD_LIMIT + 1);
    localparam logic [CW-1:0] LIMIT = CW'(RD_LIMIT);

    reply_state_t      st;
    logic [BYTE_W-1:0] val_q;
    logic [CW-1:0]     sent;
    logic              port_done;

    // A port read ends when the port runs dry or the limit is reached.
    assign port_done = port_empty || (sent == LIMIT);
    assign busy      = (st != RS_IDLE);

    // Beat content and strobes for each reply state.
    always_comb begin
        out_valid = 1'b0;
        out_data  = '0;
        out_eop   = 1'b0;
        reg_rd    = 1'b0;
        port_pop  = 1'b0;
        unique case (st)
            RS_HEAD: begin
                out_valid = 1'b1;
                out_data  = cmd_q;
            end
            RS_FETCH: reg_rd = 1'b1;
            RS_VALUE: begin
                out_valid = 1'b1;
                out_data  = val_q;
            end
            RS_PORT: begin
                out_valid = 1'b1;
                out_eop   = port_done;
                out_data  = port_done ? '0 : port_rdata;
                port_pop  = !port_done && out_ready;
            end
            RS_TAIL: begin
                out_valid = 1'b1;
                out_eop   = 1'b1;
            end
            default: out_valid = 1'b0;
        endcase
    end

    // Reply sequencing, advanced by accepted beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= RS_IDLE;
            val_q <= '0;
            sent  <= '0;
        end else begin
            unique case (st)
                RS_IDLE: if (launch) st <= RS_HEAD;
                RS_HEAD: if (out_ready) begin
                    sent <= '0;
                    st   <= is_port ? RS_PORT : RS_FETCH;
                end
                RS_FETCH: begin
                    val_q <= reg_rdata;
                    st    <= RS_VALUE;
                end
                RS_VALUE: if (out_ready) st <= RS_TAIL;
                RS_PORT: if (out_ready) begin
                    if (port_done) st <= RS_IDLE;
                    else           sent <= sent + 1'b1;
                end
                RS_TAIL: if (out_ready) st <= RS_IDLE;
                default: st <= RS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cmdpkt_decoder.sv
// Top of the command packet decoder. Joins the input parser and the reply
// builder and shares one address bus for registers and ports.
// Assumes: register read data is valid in the cycle reg_rd is high; the
// port signals refer to the port selected by bus_addr.
module cmdpkt_decoder
    import cmdpkt_pkg::*;
#(
    parameter int PORT_BASE = 96,
    parameter int RD_LIMIT  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_eop,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_eop,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              reg_wr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_rd,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic              port_push,
    output logic [BYTE_W-1:0] port_wdata,
    input  logic              port_full,
    output logic              port_pop,
    input  logic [BYTE_W-1:0] port_rdata,
    input  logic              port_empty,
    output logic              bad_pkt
);

    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(PORT_BASE);

    logic [BYTE_W-1:0] cmd_q;
    logic              launch;
    logic              reply_busy;
    logic              hold;

    // Block new input from the start pulse until the reply has ended.
    assign hold       = reply_busy || launch;
    assign bus_addr   = cmd_q[ADDR_W-1:0];
    assign port_wdata = in_data;

    cmdpkt_parser #(
        .PORT_BASE (PORT_BASE)
    ) u_parser (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_eop    (in_eop),
        .hold      (hold),
        .port_full (port_full),
        .in_ready  (in_ready),
        .cmd_q     (cmd_q),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .port_push (port_push),
        .launch    (launch),
        .bad_pkt   (bad_pkt)
    );

    cmdpkt_reply #(
        .RD_LIMIT (RD_LIMIT)
    ) u_reply (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .cmd_q      (cmd_q),
        .is_port    (cmd_q[ADDR_W-1:0] >= BASE),
        .reg_rdata  (reg_rdata),
        .port_rdata (port_rdata),
        .port_empty (port_empty),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_eop    (out_eop),
        .reg_rd     (reg_rd),
        .port_pop   (port_pop),
        .busy       (reply_busy)
    );

endmodule

// File: rtl/cmdpkt_checker.sv
// Protocol properties of the command packet decoder, bound to the top.
module cmdpkt_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       out_eop,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic       port_push,
    input logic       port_full,
    input logic       port_pop,
    input logic       port_empty,
    input logic       bad_pkt
);

    p_no_rw_clash_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));

    p_push_not_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        port_push |-> !port_full);

    p_pop_with_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        port_pop |-> (!port_empty && out_valid && out_ready));

    p_bad_no_reply_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bad_pkt |=> !out_valid);

    p_busy_stalls_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    p_beat_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_eop)));

endmodule

bind cmdpkt_decoder cmdpkt_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_eop    (out_eop),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .port_push  (port_push),
    .port_full  (port_full),
    .port_pop   (port_pop),
    .port_empty (port_empty),
    .bad_pkt    (bad_pkt)
);

// File: tb/cmdpkt_decoder_test.sv
// Scoreboard bench: stimulus tasks queue expected replies, writes and pushes;
// a negedge monitor pops and compares them.
module cmdpkt_decoder_test;

    localparam int PB  = 96;
    localparam int LIM = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_eop = 1'b0;
    logic       out_ready = 1'b1;
    logic       port_full = 1'b0;
    logic       in_ready, out_valid, out_eop, reg_wr, reg_rd, port_push, port_pop, port_empty, bad_pkt;
    logic [7:0] out_data, reg_wdata, reg_rdata, port_wdata, port_rdata;
    logic [6:0] bus_addr;

    logic [7:0] bank [0:127];
    logic [7:0] src_mem [0:15];
    int         src_rd = 0;
    int         src_wr = 0;

    logic [8:0]  exp_rep[$];
    logic [14:0] exp_wr[$];
    logic [14:0] exp_push[$];

    int total = 0;
    int bad = 0;
    int bad_seen = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    cmdpkt_decoder #(.PORT_BASE(PB), .RD_LIMIT(LIM)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_eop(in_eop), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_eop(out_eop), .bus_addr(bus_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .port_push(port_push),
        .port_wdata(port_wdata), .port_full(port_full), .port_pop(port_pop),
        .port_rdata(port_rdata), .port_empty(port_empty), .bad_pkt(bad_pkt)
    );

    // Bench-side register bank and port source.
    assign reg_rdata  = bank[bus_addr];
    assign port_rdata = src_mem[src_rd[3:0]];
    assign port_empty = (src_rd == src_wr);

    always @(posedge clk) begin
        if (reg_wr) bank[bus_addr] <= reg_wdata;
        if (port_pop) src_rd <= src_rd + 1;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: compare design activity with the scoreboard queues.
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && out_ready) begin
                if (exp_rep.size() == 0)
                    chk(1'b0, "R4 R6", "unexpected reply beat", {out_eop, out_data}, 0);
                else begin
                    logic [8:0] e;
                    e = exp_rep.pop_front();
                    chk({out_eop, out_data} == e, "R4 R6", "reply beat", {out_eop, out_data}, e);
                end
            end
            if (reg_wr) begin
                if (exp_wr.size() == 0)
                    chk(1'b0, "R3 R7", "unexpected register write", {bus_addr, reg_wdata}, 0);
                else begin
                    logic [14:0] w;
                    w = exp_wr.pop_front();
                    chk({bus_addr, reg_wdata} == w, "R3", "register write", {bus_addr, reg_wdata}, w);
                end
            end
            if (port_push) begin
                if (exp_push.size() == 0)
                    chk(1'b0, "R5", "unexpected port push", {bus_addr, port_wdata}, 0);
                else begin
                    logic [14:0] p;
                    p = exp_push.pop_front();
                    chk({bus_addr, port_wdata} == p, "R5", "port push", {bus_addr, port_wdata}, p);
                end
            end
            if (bad_pkt) bad_seen++;
        end
    end

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            chk(1'b0, "R8", "watchdog expired", cyc, 0);
            summary();
            $finish;
        end
    end

    task automatic send_tok(input bit eop, input logic [7:0] d);
        @(posedge clk); #1;
        in_valid = 1'b1; in_eop = eop; in_data = d;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1;
        in_valid = 1'b0; in_eop = 1'b0; in_data = '0;
    endtask

    task automatic drain();
        int n = 0;
        while ((exp_rep.size() != 0 || exp_wr.size() != 0 || exp_push.size() != 0) && n < 200) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic reg_write(input logic [6:0] a, input logic [7:0] v);
        exp_wr.push_back({a, v});
        send_tok(1'b0, {1'b0, a});
        send_tok(1'b0, v);
        send_tok(1'b1, 8'h00);
        drain();
    endtask

    task automatic reg_read(input logic [6:0] a, input logic [7:0] v);
        exp_rep.push_back({1'b0, 1'b1, a});
        exp_rep.push_back({1'b0, v});
        exp_rep.push_back(9'h100);
        send_tok(1'b0, {1'b1, a});
        send_tok(1'b1, 8'h00);
        drain();
    endtask

    task automatic src_put(input logic [7:0] d);
        src_mem[src_wr[3:0]] = d;
        src_wr = src_wr + 1;
    endtask

    initial begin
        int b0;
        logic [7:0] held;
        for (int i = 0; i < 128; i++) bank[i] = 8'h00;
        for (int i = 0; i < 16; i++) src_mem[i] = 8'h00;

        // R1: reset state.
        repeat (3) @(negedge clk);
        chk(!out_valid && in_ready && !reg_wr && !reg_rd && !bad_pkt && !port_push && !port_pop,
            "R1", "idle during reset", {out_valid, in_ready, reg_wr, bad_pkt}, 4'b0100);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && in_ready && !reg_wr && !reg_rd && !bad_pkt && !port_pop,
            "R1", "idle after reset", {out_valid, in_ready, reg_wr, bad_pkt}, 4'b0100);

        // R3, R4: register write then read back.
        reg_write(7'h05, 8'hA5);
        reg_read(7'h05, 8'hA5);
        // R2: last register address below the port base.
        reg_write(7'h5F, 8'h3C);
        reg_read(7'h5F, 8'h3C);
        chk(bank[7'h5F] == 8'h3C, "R2", "register 0x5F is a register", bank[7'h5F], 8'h3C);

        // R5: port write at the port base, with a full stall mid-stream.
        exp_push.push_back({7'h60, 8'h11});
        exp_push.push_back({7'h60, 8'h22});
        exp_push.push_back({7'h60, 8'h33});
        send_tok(1'b0, 8'h60);
        send_tok(1'b0, 8'h11);
        @(posedge clk); #1;
        port_full = 1'b1; in_valid = 1'b1; in_eop = 1'b0; in_data = 8'h22;
        @(negedge clk);
        chk(!in_ready && !port_push, "R5", "stall while port full", {in_ready, port_push}, 0);
        @(negedge clk);
        chk(!in_ready, "R5", "still stalled", in_ready, 0);
        @(posedge clk); #1 port_full = 1'b0;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1 in_valid = 1'b0;
        send_tok(1'b0, 8'h33);
        send_tok(1'b1, 8'h00);
        drain();
        chk(exp_push.size() == 0, "R5", "all pushes seen", exp_push.size(), 0);

        // R5: empty port write is legal.
        b0 = bad_seen;
        send_tok(1'b0, 8'h70);
        send_tok(1'b1, 8'h00);
        drain();
        chk(bad_seen == b0, "R5", "empty port write no error", bad_seen, b0);

        // R6: port read stopped by empty.
        src_put(8'hAA); src_put(8'hBB);
        exp_rep.push_back(9'h0FF); exp_rep.push_back(9'h0AA); exp_rep.push_back(9'h0BB);
        exp_rep.push_back(9'h100);
        send_tok(1'b0, 8'hFF);
        send_tok(1'b1, 8'h00);
        drain();
        chk(src_rd == src_wr, "R6", "port drained", src_wr - src_rd, 0);

        // R6: port read stopped by the length limit.
        for (int i = 0; i < 6; i++) src_put(8'h40 + 8'(i));
        exp_rep.push_back(9'h0E0);
        for (int i = 0; i < LIM; i++) exp_rep.push_back({1'b0, 8'h40 + 8'(i)});
        exp_rep.push_back(9'h100);
        send_tok(1'b0, 8'hE0);
        send_tok(1'b1, 8'h00);
        drain();
        chk(src_wr - src_rd == 2, "R6", "bytes left after limit", src_wr - src_rd, 2);
        exp_rep.push_back(9'h0E0); exp_rep.push_back(9'h044); exp_rep.push_back(9'h045);
        exp_rep.push_back(9'h100);
        send_tok(1'b0, 8'hE0);
        send_tok(1'b1, 8'h00);
        drain();

        // R7: write with no value.
        b0 = bad_seen;
        send_tok(1'b0, 8'h05);
        send_tok(1'b1, 8'h00);
        drain();
        chk(bad_seen == b0 + 1, "R7", "write without value", bad_seen - b0, 1);
        // R7: write with two values.
        b0 = bad_seen;
        send_tok(1'b0, 8'h05);
        send_tok(1'b0, 8'h77);
        send_tok(1'b0, 8'h78);
        send_tok(1'b1, 8'h00);
        drain();
        chk(bad_seen == b0 + 1, "R7", "write with extra byte", bad_seen - b0, 1);
        // R7: read with a byte before the end marker.
        b0 = bad_seen;
        send_tok(1'b0, 8'h85);
        send_tok(1'b0, 8'h01);
        send_tok(1'b1, 8'h00);
        drain();
        chk(bad_seen == b0 + 1 && !out_valid, "R7", "read with extra byte", bad_seen - b0, 1);
        // R7: end marker with no command.
        b0 = bad_seen;
        send_tok(1'b1, 8'h00);
        drain();
        chk(bad_seen == b0 + 1, "R7", "lone end marker", bad_seen - b0, 1);
        // R7: register untouched by the rejected writes.
        reg_read(7'h05, 8'hA5);

        // R8: stalled reply blocks input and holds its beat.
        out_ready = 1'b0;
        exp_rep.push_back(9'h085); exp_rep.push_back(9'h0A5); exp_rep.push_back(9'h100);
        send_tok(1'b0, 8'h85);
        send_tok(1'b1, 8'h00);
        repeat (3) @(negedge clk);
        chk(out_valid && !in_ready, "R8", "pending reply stalls input", {out_valid, in_ready}, 2'b10);
        held = out_data;
        @(negedge clk);
        chk(out_valid && out_data == held && out_data == 8'h85, "R8", "beat held", out_data, 8'h85);
        @(posedge clk); #1 out_ready = 1'b1;
        drain();

        chk(exp_rep.size() == 0 && exp_wr.size() == 0, "R4", "scoreboard empty",
            exp_rep.size() + exp_wr.size(), 0);
        summary();
        $finish;
    end

endmodule